// File: doc/BRIEF.md
# Banked Stride Prefetch Predictor

This block watches the stream of load and store accesses and predicts the next address of each memory instruction that walks through memory with a constant step. Each access arrives with three values: the program counter of the instruction, a small group number and the effective address. The group number selects one of several small banks of prediction entries. Only that bank compares its entries against the instruction, so most of the table stays idle on any given cycle. The compare key is a tag made from the low bits of the program counter, not the whole counter.

A matching entry remembers the last address of its instruction, the step between the last two addresses and a confidence state. When the step repeats often enough, the block reports a prefetch candidate one cycle after the access. The candidate is the current address plus the learned step. If no entry in the selected bank matches, an entry in that bank is replaced. Each bank picks its victim in rotating order. Issuing the memory request and any cache lookup are left to the logic around this block.

Top module: `stride_bank_prefetcher`

## Requirements
- R1: After reset `pfValid` is 0 and no entry is valid, so the first access of any instruction produces no prefetch.
- R2: While `accValid` is 1, `bankActive` has exactly the bit numbered `accGroup` set. While `accValid` is 0, `bankActive` is all zeros.
- R3: The entry tag is bits 15:0 of `accPc`. Two program counters that agree in those bits share an entry.
- R4: On a hit, the observed step is `accAddr` minus the stored previous address, taken modulo 2^32. The stored previous address is then replaced by `accAddr`. A reported prefetch appears on `pfAddr` in the cycle after the access, with `pfValid` 1, and equals `accAddr` plus the stored step.
- R5: A new entry starts in the initial state with step 0. An instruction moving by a constant nonzero step gets no prefetch on its first two accesses and gets a prefetch on its third and every later access.
- R6: No prefetch is reported while the learned step is 0, even when that step repeats.
- R7: When an entry in the steady state sees a different step, no prefetch is reported. The entry falls back to the initial state and keeps its old step. If the next step equals the old step, a prefetch is reported at once.
- R8: When an entry in the transient state sees a mismatch, it moves to the no-prediction state and learns the new step. In the no-prediction state a mismatch learns the new step again and gives no prefetch. A match moves the entry to transient, and one more match moves it to steady with a prefetch.
- R9: The banks are independent. The same program counter used with two different group numbers trains two separate entries.
- R10: On a miss, the selected bank overwrites the way its rotating pointer names and then advances the pointer. After four new tags fill a bank, a fifth new tag evicts the oldest of the four and leaves the other three intact.
- R11: A cycle with `accValid` 0 changes no entry and reports no prefetch, whatever the other inputs carry.
- R12: Steps are signed in modulo-2^32 arithmetic. A descending address stream predicts lower addresses, and sums wrap around 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accPc | input | 32 | Program counter of the memory instruction |
| accGroup | input | 4 | Bank selector for this access |
| accAddr | input | 32 | Effective address of the access |
| bankActive | output | 16 | One bit per bank, set when that bank performs compares |
| pfValid | output | 1 | A prefetch candidate is reported this cycle |
| pfAddr | output | 32 | Predicted address, meaningful while pfValid is 1 |

## Verification
The bound checker watches the bank gating on every cycle: the one-hot selection, no activity when idle, and the selected bit matching the group number. It also checks, every cycle, that an idle cycle is never followed by a prefetch, that a reported prefetch never repeats the address just seen, and that allocation and firing agree with the lookup result. Other behaviours only show up across a sequence of accesses, so only the bench scenarios can demonstrate them: the confidence walk through initial, transient, no-prediction and steady, keeping the step on a steady mismatch, sharing a tag across upper PC bits, and round-robin eviction order. Each group number and several step values are swept, and every expected address is computed arithmetically from the stream.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } conf_state_e;

  // lookup result handed from datapath to control
  typedef struct packed {
    logic        hit;
    logic        correct;
    logic        strideNz;
    conf_state_e curState;
  } lookup_stat_t;

  // strobes from control back into the datapath
  typedef struct packed {
    logic        write;
    logic        alloc;
    logic        loadStride;
    logic        fire;
    conf_state_e nextState;
  } upd_strobe_t;

endpackage

// File: rtl/stride_pf_control.sv
module stride_pf_control
  import stride_pf_pkg::*;
(
  input  logic         accValid,
  input  lookup_stat_t stat,
  output upd_strobe_t  strb
);

  always_comb begin
    strb = '0;
    strb.nextState = ST_INIT;
    if (accValid) begin
      strb.write = 1'b1;
      if (!stat.hit) begin
        strb.alloc      = 1'b1;
        strb.loadStride = 1'b1;
        strb.nextState  = ST_INIT;
      end else begin
        unique case (stat.curState)
          ST_INIT: begin
            strb.nextState  = stat.correct ? ST_STEADY : ST_TRANS;
            strb.loadStride = !stat.correct;
          end
          ST_TRANS: begin
            strb.nextState  = stat.correct ? ST_STEADY : ST_NOPRED;
            strb.loadStride = !stat.correct;
          end
          ST_STEADY: begin
            strb.nextState  = stat.correct ? ST_STEADY : ST_INIT;
            strb.loadStride = 1'b0;
          end
          ST_NOPRED: begin
            strb.nextState  = stat.correct ? ST_TRANS : ST_NOPRED;
            strb.loadStride = !stat.correct;
          end
          default: begin
            strb.nextState  = ST_INIT;
            strb.loadStride = 1'b1;
          end
        endcase
        strb.fire = stat.correct && stat.strideNz && (strb.nextState == ST_STEADY);
      end
    end
  end

endmodule

// File: rtl/stride_pf_datapath.sv
module stride_pf_datapath
  import stride_pf_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int WAYS      = 4,
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int TAG_W     = 16,
  localparam int GRP_W    = $clog2(NUM_BANKS),
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accValid,
  input  logic [PC_W-1:0]      accPc,
  input  logic [GRP_W-1:0]     accGroup,
  input  logic [ADDR_W-1:0]    accAddr,
  input  upd_strobe_t          strb,
  output lookup_stat_t         stat,
  output logic [NUM_BANKS-1:0] bankActive,
  output logic                 pfValid,
  output logic [ADDR_W-1:0]    pfAddr
);

  logic [NUM_BANKS-1:0][WAYS-1:0] validQ;
  logic [TAG_W-1:0]               tagQ    [NUM_BANKS][WAYS];
  logic [ADDR_W-1:0]              prevQ   [NUM_BANKS][WAYS];
  logic [ADDR_W-1:0]              strideQ [NUM_BANKS][WAYS];
  conf_state_e                    stateQ  [NUM_BANKS][WAYS];
  logic [WAY_W-1:0]               rrQ     [NUM_BANKS];

  logic [TAG_W-1:0]               accTag;
  logic [NUM_BANKS-1:0][WAYS-1:0] matchVec;
  logic [WAYS-1:0]                selMatch;
  logic [WAY_W-1:0]               hitWay;
  logic [WAY_W-1:0]               tgtWay;
  logic [ADDR_W-1:0]              selPrev;
  logic [ADDR_W-1:0]              selStride;
  logic [ADDR_W-1:0]              newStride;

  assign accTag = accPc[TAG_W-1:0];

  // per-bank gating: only the addressed bank runs its comparators
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankActive[b] = accValid && (accGroup == GRP_W'(b));
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign matchVec[b][w] = bankActive[b] && validQ[b][w] && (tagQ[b][w] == accTag);
    end
  end

  assign selMatch = matchVec[accGroup];

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (selMatch[w]) hitWay = WAY_W'(w);
    end
  end

  assign selPrev   = prevQ[accGroup][hitWay];
  assign selStride = strideQ[accGroup][hitWay];
  assign newStride = accAddr - selPrev;

  assign stat.hit      = |selMatch;
  assign stat.correct  = (newStride == selStride);
  assign stat.strideNz = (selStride != '0);
  assign stat.curState = stateQ[accGroup][hitWay];

  assign tgtWay = strb.alloc ? rrQ[accGroup] : hitWay;

  // control state: valid bits and replacement pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
      for (int b = 0; b < NUM_BANKS; b++) rrQ[b] <= '0;
    end else if (strb.alloc) begin
      validQ[accGroup][tgtWay] <= 1'b1;
      rrQ[accGroup]            <= rrQ[accGroup] + 1'b1;
    end
  end

  // entry payload, qualified by the valid bits
  always_ff @(posedge clk) begin
    if (strb.write) begin
      tagQ[accGroup][tgtWay]   <= accTag;
      prevQ[accGroup][tgtWay]  <= accAddr;
      stateQ[accGroup][tgtWay] <= strb.nextState;
      if (strb.loadStride)
        strideQ[accGroup][tgtWay] <= strb.alloc ? '0 : newStride;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfValid <= 1'b0;
      pfAddr  <= '0;
    end else begin
      pfValid <= strb.fire;
      if (strb.fire) pfAddr <= accAddr + selStride;
    end
  end

endmodule

// File: rtl/stride_bank_prefetcher.sv
module stride_bank_prefetcher
  import stride_pf_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int WAYS      = 4,
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int TAG_W     = 16,
  localparam int GRP_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accValid,
  input  logic [PC_W-1:0]      accPc,
  input  logic [GRP_W-1:0]     accGroup,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic [NUM_BANKS-1:0] bankActive,
  output logic                 pfValid,
  output logic [ADDR_W-1:0]    pfAddr
);

  lookup_stat_t dpStat;
  upd_strobe_t  ctlStrb;

  stride_pf_datapath #(
    .NUM_BANKS(NUM_BANKS), .WAYS(WAYS), .ADDR_W(ADDR_W),
    .PC_W(PC_W), .TAG_W(TAG_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accPc(accPc),
    .accGroup(accGroup), .accAddr(accAddr), .strb(ctlStrb), .stat(dpStat),
    .bankActive(bankActive), .pfValid(pfValid), .pfAddr(pfAddr)
  );

  stride_pf_control ctl_i (
    .accValid(accValid), .stat(dpStat), .strb(ctlStrb)
  );

endmodule

// File: rtl/stride_bank_prefetcher_chk.sv
module stride_bank_prefetcher_chk #(
  parameter int NUM_BANKS = 16,
  parameter int ADDR_W    = 32,
  localparam int GRP_W    = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accValid,
  input logic [GRP_W-1:0]     accGroup,
  input logic [ADDR_W-1:0]    accAddr,
  input logic [NUM_BANKS-1:0] bankActive,
  input logic                 pfValid,
  input logic [ADDR_W-1:0]    pfAddr,
  input logic                 lookupHit,
  input logic                 allocStrobe,
  input logic                 fireStrobe
);

  p_bank_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bankActive));

  p_bank_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |-> (bankActive == '0));

  p_bank_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |-> bankActive[accGroup]);

  p_idle_no_pf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> !pfValid);

  p_pf_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> (!pfValid || (pfAddr != $past(accAddr))));

  p_alloc_on_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    allocStrobe |-> (accValid && !lookupHit));

  p_fire_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fireStrobe |-> (accValid && lookupHit));

endmodule

bind stride_bank_prefetcher stride_bank_prefetcher_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .accValid(accValid), .accGroup(accGroup),
  .accAddr(accAddr), .bankActive(bankActive), .pfValid(pfValid),
  .pfAddr(pfAddr), .lookupHit(dpStat.hit), .allocStrobe(ctlStrb.alloc),
  .fireStrobe(ctlStrb.fire)
);

// File: tb/stride_bank_prefetcher_tb_top.sv
module stride_bank_prefetcher_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accPc = '0;
  logic [3:0]  accGroup = '0;
  logic [31:0] accAddr = '0;
  logic [15:0] bankActive;
  logic        pfValid;
  logic [31:0] pfAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stride_bank_prefetcher dut_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accPc(accPc),
    .accGroup(accGroup), .accAddr(accAddr), .bankActive(bankActive),
    .pfValid(pfValid), .pfAddr(pfAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] pc, input logic [3:0] grp, input logic [31:0] addr,
                        input bit expV, input logic [31:0] expA, input string req);
    @(negedge clk);
    accValid = 1'b1; accPc = pc; accGroup = grp; accAddr = addr;
    #1;
    chk(bankActive == (16'd1 << grp), "R2 bank select", {16'd0, bankActive}, {16'd0, 16'd1 << grp});
    @(posedge clk); #2;
    chk(pfValid == expV, {req, " pfValid"}, {31'd0, pfValid}, {31'd0, expV});
    if (expV) chk(pfAddr == expA, {req, " pfAddr"}, pfAddr, expA);
    accValid = 1'b0;
  endtask

  task automatic idle(input logic [31:0] pc, input logic [3:0] grp, input logic [31:0] addr);
    @(negedge clk);
    accValid = 1'b0; accPc = pc; accGroup = grp; accAddr = addr;
    #1;
    chk(bankActive == 16'd0, "R2 idle banks", {16'd0, bankActive}, 32'd0);
    @(posedge clk); #2;
    chk(pfValid == 1'b0, "R11 idle no prefetch", {31'd0, pfValid}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(posedge clk);
    #2;
    chk(pfValid == 1'b0, "R1 reset pfValid", {31'd0, pfValid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: first access after reset misses
    access(32'h0000_4000, 4'd3, 32'h1000, 1'b0, 0, "R1 first access");

    // R3: upper PC bits ignored for the tag
    access(32'hAAAA_1234, 4'd7, 32'h8000, 1'b0, 0, "R3 alloc");
    access(32'h1111_1234, 4'd7, 32'h8040, 1'b0, 0, "R3 second");
    access(32'h5555_1234, 4'd7, 32'h8080, 1'b1, 32'h80C0, "R3 shared tag");

    // R6: zero stride never prefetches
    access(32'h0000_0600, 4'd2, 32'h3000, 1'b0, 0, "R6 alloc");
    for (int i = 0; i < 4; i++)
      access(32'h0000_0600, 4'd2, 32'h3000, 1'b0, 0, "R6 zero stride");

    // R4 / R12: descending stream and wrap-around
    access(32'h0000_0701, 4'd1, 32'h0000_0010, 1'b0, 0, "R12 alloc");
    access(32'h0000_0701, 4'd1, 32'h0000_0008, 1'b0, 0, "R12 second");
    access(32'h0000_0701, 4'd1, 32'h0000_0000, 1'b1, 32'hFFFF_FFF8, "R12 wrap down");
    access(32'h0000_0701, 4'd1, 32'hFFFF_FFF8, 1'b1, 32'hFFFF_FFF0, "R4 next prediction");

    // R7: steady mismatch keeps stride and drops to initial
    access(32'h0000_0802, 4'd3, 32'h1000, 1'b0, 0, "R7 alloc");
    access(32'h0000_0802, 4'd3, 32'h1010, 1'b0, 0, "R7 trans");
    access(32'h0000_0802, 4'd3, 32'h1020, 1'b1, 32'h1030, "R7 steady");
    access(32'h0000_0802, 4'd3, 32'h1100, 1'b0, 0, "R7 mismatch");
    access(32'h0000_0802, 4'd3, 32'h1110, 1'b1, 32'h1120, "R7 old stride kept");

    // R8: transient -> no-prediction -> transient -> steady
    access(32'h0000_0903, 4'd4, 32'h2000, 1'b0, 0, "R8 alloc");
    access(32'h0000_0903, 4'd4, 32'h2008, 1'b0, 0, "R8 trans");
    access(32'h0000_0903, 4'd4, 32'h201C, 1'b0, 0, "R8 to nopred");
    access(32'h0000_0903, 4'd4, 32'h2020, 1'b0, 0, "R8 nopred relearn");
    access(32'h0000_0903, 4'd4, 32'h2024, 1'b0, 0, "R8 back to trans");
    access(32'h0000_0903, 4'd4, 32'h2028, 1'b1, 32'h202C, "R8 steady again");

    // R11: idle cycle with matching-looking inputs changes nothing
    idle(32'h0000_0802, 4'd3, 32'h9999_0000);
    idle(32'h0000_0903, 4'd4, 32'h0);
    access(32'h0000_0802, 4'd3, 32'h1120, 1'b1, 32'h1130, "R11 entry untouched");

    // R5 / R9: sweep every bank and several strides; same PCs in every bank
    for (int g = 0; g < 16; g++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] st;
        logic [31:0] base;
        st   = (k == 0) ? 32'd4 : (k == 1) ? 32'hFFFF_FFF8 : (k == 2) ? 32'd64 : 32'd1;
        base = 32'h0010_0000 + (g << 12) + (k << 8);
        access(32'h100 + k, g[3:0], base, 1'b0, 0, "R5 sweep first");
        access(32'h100 + k, g[3:0], base + st, 1'b0, 0, "R5 sweep second");
        access(32'h100 + k, g[3:0], base + 2 * st, 1'b1, base + 3 * st, "R5 sweep third");
      end
    end
    for (int g = 0; g < 16; g++) begin
      a = 32'h0010_0000 + (g << 12) + 32'h200 + 3 * 64;
      access(32'h102, g[3:0], a, 1'b1, a + 64, "R9 banks independent");
    end

    // R10: round-robin eviction in bank 5
    for (int t = 0; t < 4; t++) begin
      a = 32'h0050_0000 + (t << 12);
      access(32'hA00 + t, 4'd5, a, 1'b0, 0, "R10 fill");
      access(32'hA00 + t, 4'd5, a + 4, 1'b0, 0, "R10 fill");
      access(32'hA00 + t, 4'd5, a + 8, 1'b1, a + 12, "R10 fill steady");
    end
    access(32'hA04, 4'd5, 32'h0060_0000, 1'b0, 0, "R10 fifth tag");
    for (int t = 1; t < 4; t++) begin
      a = 32'h0050_0000 + (t << 12) + 12;
      access(32'hA00 + t, 4'd5, a, 1'b1, a + 4, "R10 survivor");
    end
    access(32'hA00, 4'd5, 32'h0050_000C, 1'b0, 0, "R10 oldest evicted");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule